// File: doc/BRIEF.md
# Media Command Header Decoder

This block sits at the front of a media co-processor and takes in a stream of 32-bit command dwords through a valid/ready handshake. The first dword of each command is a header. The decoder checks the fixed type fields in that header and reads the sub-command code and the length field. It then counts the body dwords that follow. On the last body dword it applies the payload: it updates the mode and configuration registers, raises load requests for firmware or data, or emits a start pulse.

The firmware-load command is qualified twice. It needs the authentication-ok input high when the command completes, and it needs a non-zero descriptor. If either condition fails, the command is consumed silently and nothing is loaded. A load request stays high until the load engine returns an acknowledge. While a request is outstanding, the decoder refuses the next header.

A malformed header puts the decoder into a discard state and sets a sticky error flag. It stays in that state until a soft reset. A known command with the wrong length is also flagged. Its body is skipped and its payload is not applied.

Top module: `mcmd_decoder`

## Requirements
- R1: After reset `in_ready` is 1 and every request, status and error output is 0. While a firmware or data request is pending, `in_ready` is 0 whenever the decoder waits for a header.
- R2: A header is accepted only when bits 31:29 equal 3, bits 28:27 equal 2 and bits 26:23 equal 0xB. Any other header sets `err`, which stays set. After such a header every dword is accepted and discarded, with no effect on any output, until `soft_rst`.
- R3: A header whose sub-command (bits 22:16) is not one of 0, 1, 2, 3, 4, 5, 32 or 33 behaves as in R2.
- R4: The length field (bits 11:0) must equal the command's total dword count minus 2. The totals are: 0→3, 1→5, 2→6, 3→2, 4→49, 5→11, 32→5, 33→2. On a mismatch `err` is set, the length+1 dwords that follow are consumed without effect, and decoding resumes at the next header.
- R5: Sub-command 1 takes its descriptor from bits 7:0 of its 4th body dword. If that descriptor is non-zero and `auth_ok` is 1 when the last dword is accepted, the decoder raises `fw_req` and drives `fw_desc` with the descriptor.
- R6: A sub-command 1 with `auth_ok` low or a zero descriptor raises no request, and `fw_loaded` stays 0.
- R7: `load_ack` clears any pending request. If a firmware request was pending, `load_ack` also sets `fw_loaded`.
- R8: Sub-command 2 raises `dma_req`. It drives `dma_src` with address bits 47:6, taken from body dword 1 bits 31:6 (low part) and body dword 2 bits 15:0 (high part). It drives `dma_dst` from body dword 4 bits 16:6 and `dma_lines` from body dword 5 bits 16:6, both counted in 64-byte lines.
- R9: Sub-command 3 sets `core_rst` to bit 0 of its body dword: 1 holds the embedded core in reset and 0 releases it.
- R10: Sub-command 0 sets `stream_out_en` to bit 4 of its first body dword.
- R11: Sub-command 33 drives `start_pulse` high for exactly one cycle and sets `start_last` to bit 0 of its body dword.
- R12: Sub-commands 4, 5 and 32 are consumed without changing any output.
- R13: `soft_rst` clears `err` and returns the decoder to header parsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous resynchronisation, clears error and parser state |
| in_valid | input | 1 | Command dword valid |
| in_data | input | 32 | Command dword |
| in_ready | output | 1 | Decoder accepts the dword |
| auth_ok | input | 1 | Firmware authentication succeeded |
| load_ack | input | 1 | Load engine finished the pending request |
| stream_out_en | output | 1 | Stream output mode from sub-command 0 |
| fw_req | output | 1 | Firmware load request, held until ack |
| fw_desc | output | DESC_W | Firmware descriptor |
| fw_loaded | output | 1 | Firmware load acknowledged |
| dma_req | output | 1 | Data load request, held until ack |
| dma_src | output | ADDR_W-LINE_SHIFT | Source address in 64-byte lines |
| dma_dst | output | LINE_W | Destination line index |
| dma_lines | output | LINE_W | Length in 64-byte lines |
| core_rst | output | 1 | Embedded core forced reset |
| start_pulse | output | 1 | One-cycle start strobe |
| start_last | output | 1 | Start marks last stream object |
| err | output | 1 | Sticky decode error |

## Verification
The case that needs care is an acknowledge that arrives in the same cycle that a new header is offered while a request is pending. The bench holds a start header on the input, raises `load_ack` in the same cycle, and checks three things. `in_ready` must be 0 in that cycle. The request and `fw_loaded` must update at the next edge. The header must be taken one cycle later, and its start pulse must follow on schedule. A second overlap, a length error followed directly by a valid command, checks that the skip counter hands control back to the next header without losing it.

// File: rtl/mcmd_pkg.sv
package mcmd_pkg;
   localparam int unsigned HDR_LEN_W = 12;
   localparam int unsigned CNT_W     = HDR_LEN_W + 1;
   localparam logic [2:0]  HDR_TYPE  = 3'd3;
   localparam logic [1:0]  HDR_PIPE  = 2'd2;
   localparam logic [3:0]  HDR_OPC   = 4'hB;

   typedef enum logic [6:0] {
      SC_MODE    = 7'd0,
      SC_FW      = 7'd1,
      SC_DATA    = 7'd2,
      SC_CFG     = 7'd3,
      SC_VADDR   = 7'd4,
      SC_INDBASE = 7'd5,
      SC_STREAM  = 7'd32,
      SC_START   = 7'd33
   } sub_e;

   typedef enum logic [1:0] {ST_HDR, ST_BODY, ST_SKIP} st_e;

   // total dwords of a command, 0 for an unknown code
   function automatic logic [CNT_W-1:0] cmd_dwords(input logic [6:0] sub);
      case (sub)
         SC_MODE:    cmd_dwords = CNT_W'(3);
         SC_FW:      cmd_dwords = CNT_W'(5);
         SC_DATA:    cmd_dwords = CNT_W'(6);
         SC_CFG:     cmd_dwords = CNT_W'(2);
         SC_VADDR:   cmd_dwords = CNT_W'(49);
         SC_INDBASE: cmd_dwords = CNT_W'(11);
         SC_STREAM:  cmd_dwords = CNT_W'(5);
         SC_START:   cmd_dwords = CNT_W'(2);
         default:    cmd_dwords = '0;
      endcase
   endfunction
endpackage

// File: rtl/mcmd_hdr_chk.sv
module mcmd_hdr_chk
   import mcmd_pkg::*;
(
   input  logic [31:0]          hdr,
   output logic                 tuple_ok,
   output logic                 sub_known,
   output logic                 len_ok,
   output logic [6:0]           sub,
   output logic [HDR_LEN_W-1:0] len
);
   logic [CNT_W-1:0] total;

   always_comb begin
      sub       = hdr[22:16];
      len       = hdr[HDR_LEN_W-1:0];
      tuple_ok  = (hdr[31:29] == HDR_TYPE) && (hdr[28:27] == HDR_PIPE) &&
                  (hdr[26:23] == HDR_OPC);
      total     = cmd_dwords(sub);
      sub_known = (total != '0);
      len_ok    = sub_known && ({1'b0, len} == (total - CNT_W'(2)));
   end
endmodule

// File: rtl/mcmd_seq.sv
module mcmd_seq
   import mcmd_pkg::*;
#(
   parameter bit LEN_RESYNC = 1'b0
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 tuple_ok,
   input  logic                 sub_known,
   input  logic                 len_ok,
   input  logic [6:0]           sub,
   input  logic [HDR_LEN_W-1:0] len,
   input  logic                 pend,
   output logic                 body_we,
   output logic [CNT_W-1:0]     idx,
   output logic [6:0]           cur_sub,
   output logic                 commit,
   output logic                 err
);
   st_e              state;
   logic [CNT_W-1:0] rem;
   logic             drop;
   logic             accept;
   logic             len_bad_goes_skip;

   generate
      if (LEN_RESYNC) begin : g_len_skip
         assign len_bad_goes_skip = 1'b1;
      end else begin : g_len_count
         assign len_bad_goes_skip = 1'b0;
      end
   endgenerate

   always_comb begin
      case (state)
         ST_HDR:  in_ready = !pend;
         default: in_ready = 1'b1;
      endcase
      accept  = in_valid && in_ready && !soft_rst;
      body_we = accept && (state == ST_BODY);
      commit  = body_we && (rem == CNT_W'(1)) && !drop;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_HDR;
         rem     <= '0;
         idx     <= '0;
         cur_sub <= '0;
         drop    <= 1'b0;
         err     <= 1'b0;
      end else if (soft_rst) begin
         state <= ST_HDR;
         drop  <= 1'b0;
         err   <= 1'b0;
      end else if (accept) begin
         case (state)
            ST_HDR: begin
               if (!tuple_ok || !sub_known) begin
                  err   <= 1'b1;
                  state <= ST_SKIP;
               end else begin
                  rem     <= {1'b0, len} + CNT_W'(1);
                  idx     <= '0;
                  cur_sub <= sub;
                  drop    <= !len_ok;
                  if (!len_ok) err <= 1'b1;
                  state   <= (!len_ok && len_bad_goes_skip) ? ST_SKIP : ST_BODY;
               end
            end
            ST_BODY: begin
               rem <= rem - CNT_W'(1);
               idx <= idx + CNT_W'(1);
               if (rem == CNT_W'(1)) state <= ST_HDR;
            end
            default: state <= ST_SKIP;
         endcase
      end
   end

   // R2: the error flag only drops through soft reset
   assert_err_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !soft_rst) |=> err);
   // R2: once discarding, no payload is ever applied before soft reset
   assert_skip_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP && !soft_rst) |=> (state == ST_SKIP));
   // R4: a body is counted down to completion one dword per accept
   assert_body_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (body_we && rem != CNT_W'(1) && !soft_rst) |=> (state == ST_BODY));
endmodule

// File: rtl/mcmd_exec.sv
module mcmd_exec
   import mcmd_pkg::*;
#(
   parameter int unsigned ADDR_W     = 48,
   parameter int unsigned LINE_SHIFT = 6,
   parameter int unsigned LINE_W     = 11,
   parameter int unsigned DESC_W     = 8,
   parameter int unsigned SHADOW_N   = 5
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [31:0]                  in_data,
   input  logic                         body_we,
   input  logic [CNT_W-1:0]             idx,
   input  logic [6:0]                   cur_sub,
   input  logic                         commit,
   input  logic                         auth_ok,
   input  logic                         load_ack,
   output logic                         pend,
   output logic                         stream_out_en,
   output logic                         fw_req,
   output logic [DESC_W-1:0]            fw_desc,
   output logic                         fw_loaded,
   output logic                         dma_req,
   output logic [ADDR_W-LINE_SHIFT-1:0] dma_src,
   output logic [LINE_W-1:0]            dma_dst,
   output logic [LINE_W-1:0]            dma_lines,
   output logic                         core_rst,
   output logic                         start_pulse,
   output logic                         start_last
);
   localparam int unsigned HI_W = ADDR_W - 32;
   localparam int unsigned LO_W = 32 - LINE_SHIFT;
   localparam int unsigned FHI  = LINE_SHIFT + LINE_W - 1;

   logic [31:0] shadow [SHADOW_N];
   logic [31:0] cur    [SHADOW_N];
   logic [DESC_W-1:0] new_desc;

   generate
      for (genvar k = 0; k < SHADOW_N; k++) begin : g_shadow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                shadow[k] <= '0;
            else if (body_we && idx == CNT_W'(k))      shadow[k] <= in_data;
         end
         assign cur[k] = (body_we && idx == CNT_W'(k)) ? in_data : shadow[k];
      end
   endgenerate

   assign new_desc = cur[3][DESC_W-1:0];
   assign pend     = fw_req || dma_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stream_out_en <= 1'b0;
         fw_req        <= 1'b0;
         fw_desc       <= '0;
         fw_loaded     <= 1'b0;
         dma_req       <= 1'b0;
         dma_src       <= '0;
         dma_dst       <= '0;
         dma_lines     <= '0;
         core_rst      <= 1'b0;
         start_pulse   <= 1'b0;
         start_last    <= 1'b0;
      end else begin
         start_pulse <= 1'b0;
         if (load_ack) begin
            if (fw_req) fw_loaded <= 1'b1;
            fw_req  <= 1'b0;
            dma_req <= 1'b0;
         end
         if (commit) begin
            case (cur_sub)
               SC_MODE: stream_out_en <= cur[0][4];
               SC_FW: begin
                  if (auth_ok && new_desc != '0) begin
                     fw_req  <= 1'b1;
                     fw_desc <= new_desc;
                  end
               end
               SC_DATA: begin
                  dma_req   <= 1'b1;
                  dma_src   <= {cur[1][HI_W-1:0], cur[0][31:LINE_SHIFT]};
                  dma_dst   <= cur[3][FHI:LINE_SHIFT];
                  dma_lines <= cur[4][FHI:LINE_SHIFT];
               end
               SC_CFG: core_rst <= cur[0][0];
               SC_START: begin
                  start_pulse <= 1'b1;
                  start_last  <= cur[0][0];
               end
               default: ;
            endcase
         end
      end
   end

   // R1: at most one load request can be outstanding
   assert_one_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({fw_req, dma_req}) <= 1);
   // R6: a firmware request never rises with a zero descriptor
   assert_fw_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fw_req) |-> (fw_desc != '0));
   // R7: firmware loaded status only follows an acknowledged firmware request
   assert_loaded_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fw_loaded) |-> ($past(fw_req) && $past(load_ack)));
   // R11: the start strobe lasts a single cycle
   assert_start_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);
   // R5: a held request keeps its descriptor until acknowledged
   assert_desc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_req && !load_ack) |=> (fw_req && $stable(fw_desc)));
endmodule

// File: rtl/mcmd_decoder.sv
module mcmd_decoder
   import mcmd_pkg::*;
#(
   parameter int unsigned ADDR_W     = 48,
   parameter int unsigned LINE_SHIFT = 6,
   parameter int unsigned LINE_W     = 11,
   parameter int unsigned DESC_W     = 8,
   parameter bit          LEN_RESYNC = 1'b0
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         soft_rst,
   input  logic                         in_valid,
   input  logic [31:0]                  in_data,
   output logic                         in_ready,
   input  logic                         auth_ok,
   input  logic                         load_ack,
   output logic                         stream_out_en,
   output logic                         fw_req,
   output logic [DESC_W-1:0]            fw_desc,
   output logic                         fw_loaded,
   output logic                         dma_req,
   output logic [ADDR_W-LINE_SHIFT-1:0] dma_src,
   output logic [LINE_W-1:0]            dma_dst,
   output logic [LINE_W-1:0]            dma_lines,
   output logic                         core_rst,
   output logic                         start_pulse,
   output logic                         start_last,
   output logic                         err
);
   localparam int unsigned SHADOW_N = 5;

   generate
      if (ADDR_W <= 32 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W must lie in 33..64");
      end
      if (LINE_SHIFT + LINE_W > 32 || LINE_SHIFT >= 32) begin : g_bad_line
         $error("line field must fit in one dword");
      end
      if (DESC_W == 0 || DESC_W > 32) begin : g_bad_desc
         $error("DESC_W must lie in 1..32");
      end
   endgenerate

   logic                 tuple_ok, sub_known, len_ok, pend, body_we, commit;
   logic [6:0]           sub, cur_sub;
   logic [HDR_LEN_W-1:0] len;
   logic [CNT_W-1:0]     idx;

   mcmd_hdr_chk u_chk (
      .hdr(in_data), .tuple_ok(tuple_ok), .sub_known(sub_known),
      .len_ok(len_ok), .sub(sub), .len(len)
   );

   mcmd_seq #(.LEN_RESYNC(LEN_RESYNC)) u_seq (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .in_valid(in_valid),
      .in_ready(in_ready), .tuple_ok(tuple_ok), .sub_known(sub_known),
      .len_ok(len_ok), .sub(sub), .len(len), .pend(pend), .body_we(body_we),
      .idx(idx), .cur_sub(cur_sub), .commit(commit), .err(err)
   );

   mcmd_exec #(
      .ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT), .LINE_W(LINE_W),
      .DESC_W(DESC_W), .SHADOW_N(SHADOW_N)
   ) u_exec (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .body_we(body_we),
      .idx(idx), .cur_sub(cur_sub), .commit(commit), .auth_ok(auth_ok),
      .load_ack(load_ack), .pend(pend), .stream_out_en(stream_out_en),
      .fw_req(fw_req), .fw_desc(fw_desc), .fw_loaded(fw_loaded),
      .dma_req(dma_req), .dma_src(dma_src), .dma_dst(dma_dst),
      .dma_lines(dma_lines), .core_rst(core_rst), .start_pulse(start_pulse),
      .start_last(start_last)
   );
endmodule

// File: tb/mcmd_decoder_tb_top.sv
`timescale 1ns/1ps
module mcmd_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        auth_ok = 1'b0;
   logic        load_ack = 1'b0;
   logic        stream_out_en, fw_req, fw_loaded, dma_req, core_rst;
   logic        start_pulse, start_last, err;
   logic [7:0]  fw_desc;
   logic [41:0] dma_src;
   logic [10:0] dma_dst, dma_lines;

   int n_run = 0;
   int n_fail = 0;

   logic [31:0] body [64];
   logic        e_so, e_fw, e_loaded, e_dma, e_core, e_err, e_last;
   logic [7:0]  e_desc;
   logic [41:0] e_src;
   logic [10:0] e_dst, e_lines;

   always #5 clk = ~clk;

   mcmd_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .in_valid(in_valid),
      .in_data(in_data), .in_ready(in_ready), .auth_ok(auth_ok),
      .load_ack(load_ack), .stream_out_en(stream_out_en), .fw_req(fw_req),
      .fw_desc(fw_desc), .fw_loaded(fw_loaded), .dma_req(dma_req),
      .dma_src(dma_src), .dma_dst(dma_dst), .dma_lines(dma_lines),
      .core_rst(core_rst), .start_pulse(start_pulse), .start_last(start_last),
      .err(err)
   );

   function automatic logic [31:0] hdr(input logic [6:0] sub, input logic [11:0] len);
      return {3'd3, 2'd2, 4'hB, sub, 4'h0, len};
   endfunction

   function automatic int total_dw(input logic [6:0] sub);
      case (sub)
         7'd0: return 3;  7'd1: return 5;  7'd2: return 6;  7'd3: return 2;
         7'd4: return 49; 7'd5: return 11; 7'd32: return 5; 7'd33: return 2;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk({tag, " stream_out_en"}, 64'(stream_out_en), 64'(e_so));
      chk({tag, " fw_req"},        64'(fw_req),        64'(e_fw));
      chk({tag, " fw_desc"},       64'(fw_desc),       64'(e_desc));
      chk({tag, " fw_loaded"},     64'(fw_loaded),     64'(e_loaded));
      chk({tag, " dma_req"},       64'(dma_req),       64'(e_dma));
      chk({tag, " dma_src"},       64'(dma_src),       64'(e_src));
      chk({tag, " dma_dst"},       64'(dma_dst),       64'(e_dst));
      chk({tag, " dma_lines"},     64'(dma_lines),     64'(e_lines));
      chk({tag, " core_rst"},      64'(core_rst),      64'(e_core));
      chk({tag, " start_last"},    64'(start_last),    64'(e_last));
      chk({tag, " err"},           64'(err),           64'(e_err));
   endtask

   // called at a negedge; returns at the negedge after the accepting edge
   task automatic put(input logic [31:0] d);
      in_valid = 1'b1;
      in_data  = d;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send(input logic [6:0] sub, input logic [11:0] len, input int nbody);
      put(hdr(sub, len));
      for (int i = 0; i < nbody; i++) put(body[i]);
   endtask

   task automatic send_ok(input logic [6:0] sub);
      send(sub, 12'(total_dw(sub) - 2), total_dw(sub) - 1);
   endtask

   task automatic do_ack();
      load_ack = 1'b1;
      @(negedge clk);
      load_ack = 1'b0;
      if (e_fw) e_loaded = 1'b1;
      e_fw  = 1'b0;
      e_dma = 1'b0;
   endtask

   task automatic do_soft();
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      e_err = 1'b0;
   endtask

   task automatic junk(input int n);
      for (int i = 0; i < n; i++) body[i] = $urandom;
   endtask

   // model of the payload effect of a well-formed command
   task automatic model(input logic [6:0] sub);
      case (sub)
         7'd0: e_so = body[0][4];
         7'd1: if (auth_ok && body[3][7:0] != 8'd0) begin
                  e_fw = 1'b1; e_desc = body[3][7:0];
               end
         7'd2: begin
                  e_dma = 1'b1; e_src = {body[1][15:0], body[0][31:6]};
                  e_dst = body[3][16:6]; e_lines = body[4][16:6];
               end
         7'd3: e_core = body[0][0];
         7'd33: e_last = body[0][0];
         default: ;
      endcase
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      {e_so, e_fw, e_loaded, e_dma, e_core, e_err, e_last} = '0;
      e_desc = '0; e_src = '0; e_dst = '0; e_lines = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 reset in_ready", 64'(in_ready), 64'd1);
      chk("R1 reset start_pulse", 64'(start_pulse), 64'd0);
      chk_all("R1 reset");

      // R10 mode select
      junk(2); body[0][4] = 1'b1; send_ok(7'd0); model(7'd0);
      chk_all("R10 mode on");
      body[0][4] = 1'b0; send_ok(7'd0); model(7'd0);
      chk_all("R10 mode off");

      // R9 config reset
      body[0] = 32'h1; send_ok(7'd3); model(7'd3); chk_all("R9 core reset set");
      body[0] = 32'hFFFF_FFFE; send_ok(7'd3); model(7'd3); chk_all("R9 core reset clear");

      // R6 aborted firmware loads
      auth_ok = 1'b0; junk(4); body[3][7:0] = 8'h5A; send_ok(7'd1); model(7'd1);
      chk_all("R6 auth low");
      auth_ok = 1'b1; body[3][7:0] = 8'h00; send_ok(7'd1); model(7'd1);
      chk_all("R6 zero descriptor");

      // R5 successful firmware request
      body[3][7:0] = 8'hC3; send_ok(7'd1); model(7'd1);
      chk_all("R5 fw request");

      // R1 header blocked while pending; ack lands in same cycle as offered header
      body[0] = 32'h1;
      in_valid = 1'b1; in_data = hdr(7'd33, 12'd0); load_ack = 1'b1;
      #1 chk("R1 ready low while pending", 64'(in_ready), 64'd0);
      @(negedge clk);
      load_ack = 1'b0; e_fw = 1'b0; e_loaded = 1'b1;
      #1 chk("R1 ready after ack", 64'(in_ready), 64'd1);
      chk_all("R7 ack clears fw request");
      @(posedge clk);
      @(negedge clk);
      put(body[0]); model(7'd33);
      chk("R11 start pulse high", 64'(start_pulse), 64'd1);
      chk_all("R11 start fields");
      @(negedge clk);
      chk("R11 start pulse single", 64'(start_pulse), 64'd0);

      // R8 data load
      junk(5); send_ok(7'd2); model(7'd2); chk_all("R8 data load");
      do_ack(); chk_all("R7 data ack");

      // R12 consumed-only commands
      junk(48); send_ok(7'd4); chk_all("R12 vaddr");
      junk(10); send_ok(7'd5); chk_all("R12 indbase");
      junk(4);  send_ok(7'd32); chk_all("R12 stream");

      // R4 length mismatch, then immediate valid command
      body[0] = 32'h1; body[1] = 32'h1; body[2] = 32'h1; body[3] = 32'h1;
      send(7'd3, 12'd3, 4); e_err = 1'b1;
      chk_all("R4 bad length ignored");
      body[0] = 32'h1; send_ok(7'd3); model(7'd3);
      chk_all("R4 decode resumes");
      do_soft(); chk_all("R13 soft clears err");

      // R2 bad tuple then discard
      put({3'd2, 2'd2, 4'hB, 7'd3, 4'h0, 12'd0}); e_err = 1'b1;
      chk_all("R2 bad tuple");
      body[0] = 32'h0; send_ok(7'd3);
      chk_all("R2 discarded after error");
      do_soft(); chk_all("R13 soft after tuple");
      body[0] = 32'h0; send_ok(7'd3); model(7'd3);
      chk_all("R13 decode after soft");

      // R3 unknown sub-command
      put(hdr(7'd7, 12'd0)); e_err = 1'b1;
      chk_all("R3 unknown sub");
      body[0] = 32'h1; send_ok(7'd0);
      chk_all("R3 discarded");
      do_soft();

      // random mix
      for (int n = 0; n < 60; n++) begin
         int k;
         logic [6:0] s;
         k = $urandom_range(0, 6);
         case (k)
            0: s = 7'd0; 1: s = 7'd1; 2: s = 7'd2; 3: s = 7'd3;
            4: s = 7'd33; 5: s = 7'd5; default: s = 7'd32;
         endcase
         junk(10);
         if ($urandom_range(0, 3) == 0) body[3][7:0] = 8'h00;
         auth_ok = 1'($urandom_range(0, 1));
         send_ok(s); model(s);
         chk_all($sformatf("R5 R8 R9 R10 R11 R12 random cmd %0d", s));
         if (e_fw || e_dma) begin
            do_ack();
            chk_all("R7 random ack");
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule